// File: doc/BRIEF.md
# SD Host Interrupt Status Unit

This block gathers event pulses from an SD host controller's command path, data path and card-presence logic into one 32-bit interrupt status register. Each status bit latches only while its status-enable bit is set. It stays set until software writes a 1 to it. A second, independent signal-enable mask decides which latched bits drive the single interrupt line to the processor. The error bits are also folded into two summary outputs: one for command-path errors and one for any error.

The same small register bus gives access to a system-control word. That word holds three self-clearing software resets: whole-controller, command line and data line. A reset bit starts a fixed-length pulse that the rest of the controller sees on a dedicated output, and software can poll the bit until it drops. While a reset is active, it clears the status bits of its own path. The whole-controller reset also clears both enable masks.

Top module: `sd_irq_status_unit`

## Requirements
- R1: An event pulse on `evt_i[n]` sets status bit n at the next clock edge only if status-enable bit n is 1; with the enable at 0 the pulse is dropped. Implemented bits: 0 command done, 1 transfer done, 2 block gap, 3 DMA done, 4 write buffer ready, 5 read buffer ready, 6 card inserted, 7 card removed, 8 card interrupt, 16 command timeout, 17 command CRC, 18 command end-bit, 19 command index, 20 data timeout, 21 data CRC, 22 data end-bit, 28 DMA error.
- R2: Writing the status register (select 0) clears every bit written as 1; bits written as 0 keep their value.
- R3: If an enabled event and a write-1-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R4: `irq_o` is a register that takes the OR of (status AND signal-enable) one cycle later. A bit whose signal-enable (select 2) is 0 still latches in status but does not raise `irq_o`.
- R5: `cmd_err_o` is 1 exactly when any of status bits 17, 18 or 19 is set. `err_any_o` is 1 exactly when any of bits 16 to 22 or bit 28 is set. Bit 16 alone does not raise `cmd_err_o`.
- R6: Writing 1 to system-control (select 3) bit 24, 25 or 26 sets that bit, and the matching output `rst_all_o`, `rst_cmd_o` or `rst_dat_o`, for exactly RST_CYCLES cycles, starting with the cycle after the write. The bit then reads 0 again.
- R7: While the whole-controller reset (bit 24) is active, all status bits and both enable masks are held at 0.
- R8: While the command-line reset is active, status bits 0 and 16 to 19 are held at 0. While the data-line reset is active, status bits 1 to 5, 20 to 22 and 28 are held at 0. Neither reset touches any other bit, and the card bits 6 to 8 survive both.
- R9: Bits that are not implemented always read 0 in the status and both enable registers, and they never latch.
- R10: After `rst_n`, all registers read 0 and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel_i | input | 2 | Register select: 0 status, 1 status-enable, 2 signal-enable, 3 system control |
| reg_we_i | input | 1 | Write strobe for the selected register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the selected register (combinational) |
| evt_i | input | 32 | Single-cycle event pulses, one per status bit position |
| irq_o | output | 1 | Interrupt line to the processor |
| cmd_err_o | output | 1 | Command-path error summary |
| err_any_o | output | 1 | Summary of all error bits |
| rst_all_o | output | 1 | Whole-controller reset pulse |
| rst_cmd_o | output | 1 | Command-line reset pulse |
| rst_dat_o | output | 1 | Data-line reset pulse |

## Verification
A pulse or write presented before clock edge k shows in the status read data and the summary outputs right after edge k. `irq_o` follows one edge later, at k+1. A reset bit reads 1 from edge k through edge k+RST_CYCLES-1 and reads 0 after edge k+RST_CYCLES. The bench changes inputs and samples outputs only on falling edges. Every check is placed at a counted number of edges after its stimulus, and the latency checks sample both the last cycle before the change and the first cycle after it.

// File: rtl/sd_irq_pkg.sv
// Package: shared constants and register selects for the SD interrupt status unit.
// Assumes a 32-bit register word with fixed event bit positions.
package sd_irq_pkg;
    localparam int REG_W = 32;

    // Register select codes on the register bus
    typedef enum logic [1:0] {
        SEL_STATUS  = 2'd0,
        SEL_STAT_EN = 2'd1,
        SEL_SIG_EN  = 2'd2,
        SEL_SYSCTL  = 2'd3
    } reg_sel_e;

    // Implemented status bit positions
    localparam logic [REG_W-1:0] IMPL_MASK     = 32'h107F_01FF;
    // Bits owned by the command path
    localparam logic [REG_W-1:0] CMD_PATH_MASK = 32'h000F_0001;
    // Bits owned by the data path
    localparam logic [REG_W-1:0] DAT_PATH_MASK = 32'h1070_003E;
    // Command error group: index, end-bit, CRC
    localparam logic [REG_W-1:0] CMD_ERR_MASK  = 32'h000E_0000;
    // All error bits
    localparam logic [REG_W-1:0] ERR_MASK      = 32'h107F_0000;

    // System-control position of the first reset bit (all, cmd, data follow)
    localparam int RST_BASE  = 24;
    localparam int RST_LINES = 3;
endpackage

// File: rtl/sd_rst_timer.sv
// Module: one self-clearing reset pulse generator.
// A start strobe (re)loads a down-counter; the output is high while it is non-zero.
// Assumes CYCLES >= 1.
module sd_rst_timer #(
    parameter int CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic active_o
);
    localparam int CNT_W = $clog2(CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES);

    logic [CNT_W-1:0] cnt_q;

    // Load on start, count down to zero otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start_i)
            cnt_q <= LOAD;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign active_o = (cnt_q != '0);
endmodule

// File: rtl/sd_irq_status_reg.sv
// Module: status, status-enable and signal-enable registers plus the interrupt flop.
// Assumes one-cycle event pulses; an event beats a same-cycle clear.
// Path clears coming from active resets take precedence over everything.
module sd_irq_status_reg
    import sd_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] evt_i,
    input  logic [REG_W-1:0] w1c_i,
    input  logic             sten_we_i,
    input  logic             sigen_we_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic [REG_W-1:0] path_clr_i,
    input  logic             en_clr_i,
    output logic [REG_W-1:0] status_o,
    output logic [REG_W-1:0] sten_o,
    output logic [REG_W-1:0] sigen_o,
    output logic             irq_o
);
    logic [REG_W-1:0] status_q, sten_q, sigen_q;
    logic [REG_W-1:0] set_vec, status_d;
    logic             irq_q;

    // Next status: clear by write and by path reset, then set by enabled events
    always_comb begin
        set_vec  = evt_i & sten_q & IMPL_MASK & ~path_clr_i;
        status_d = (status_q & ~w1c_i & ~path_clr_i) | set_vec;
    end

    // Status register update
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end

    // Status-enable mask: cleared by the global reset, else written
    always_ff @(posedge clk) begin
        if (!rst_n || en_clr_i) sten_q <= '0;
        else if (sten_we_i)     sten_q <= wdata_i & IMPL_MASK;
    end

    // Signal-enable mask: cleared by the global reset, else written
    always_ff @(posedge clk) begin
        if (!rst_n || en_clr_i) sigen_q <= '0;
        else if (sigen_we_i)    sigen_q <= wdata_i & IMPL_MASK;
    end

    // Registered interrupt line
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(status_q & sigen_q);
    end

    assign status_o = status_q;
    assign sten_o   = sten_q;
    assign sigen_o  = sigen_q;
    assign irq_o    = irq_q;
endmodule

// File: rtl/sd_irq_status_unit.sv
// Module: SD host interrupt status unit top.
// Decodes the register bus, runs three self-clearing reset timers, and
// produces the error summaries. Assumes reads have no side effects.
module sd_irq_status_unit
    import sd_irq_pkg::*;
#(
    parameter int RST_CYCLES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       reg_sel_i,
    input  logic             reg_we_i,
    input  logic [REG_W-1:0] reg_wdata_i,
    output logic [REG_W-1:0] reg_rdata_o,
    input  logic [REG_W-1:0] evt_i,
    output logic             irq_o,
    output logic             cmd_err_o,
    output logic             err_any_o,
    output logic             rst_all_o,
    output logic             rst_cmd_o,
    output logic             rst_dat_o
);
    reg_sel_e               sel;
    logic [REG_W-1:0]       status_q, sten_q, sigen_q;
    logic [REG_W-1:0]       w1c, path_clr, sysctl_rd;
    logic [RST_LINES-1:0]   rst_start, rst_act;

    assign sel = reg_sel_e'(reg_sel_i);

    // Reset timers, one per system-control reset bit
    for (genvar g = 0; g < RST_LINES; g++) begin : g_rst
        assign rst_start[g] = reg_we_i && (sel == SEL_SYSCTL) && reg_wdata_i[RST_BASE + g];
        sd_rst_timer #(.CYCLES(RST_CYCLES)) u_tmr (
            .clk      (clk),
            .rst_n    (rst_n),
            .start_i  (rst_start[g]),
            .active_o (rst_act[g])
        );
    end

    // Write decode and per-path clear masks
    always_comb begin
        w1c      = (reg_we_i && sel == SEL_STATUS) ? reg_wdata_i : '0;
        path_clr = '0;
        if (rst_act[0]) path_clr = '1;
        if (rst_act[1]) path_clr = path_clr | CMD_PATH_MASK;
        if (rst_act[2]) path_clr = path_clr | DAT_PATH_MASK;
    end

    sd_irq_status_reg u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt_i),
        .w1c_i      (w1c),
        .sten_we_i  (reg_we_i && sel == SEL_STAT_EN),
        .sigen_we_i (reg_we_i && sel == SEL_SIG_EN),
        .wdata_i    (reg_wdata_i),
        .path_clr_i (path_clr),
        .en_clr_i   (rst_act[0]),
        .status_o   (status_q),
        .sten_o     (sten_q),
        .sigen_o    (sigen_q),
        .irq_o      (irq_o)
    );

    // Read-back mux
    always_comb begin
        sysctl_rd = '0;
        sysctl_rd[RST_BASE +: RST_LINES] = rst_act;
        unique case (sel)
            SEL_STATUS:  reg_rdata_o = status_q;
            SEL_STAT_EN: reg_rdata_o = sten_q;
            SEL_SIG_EN:  reg_rdata_o = sigen_q;
            default:     reg_rdata_o = sysctl_rd;
        endcase
    end

    assign cmd_err_o = |(status_q & CMD_ERR_MASK);
    assign err_any_o = |(status_q & ERR_MASK);
    assign rst_all_o = rst_act[0];
    assign rst_cmd_o = rst_act[1];
    assign rst_dat_o = rst_act[2];
endmodule

// File: rtl/sd_irq_checker.sv
// Module: assertion checker for the SD interrupt status unit, bound to the top.
// Counts the high time of each reset line to check the self-clear window.
module sd_irq_checker
    import sd_irq_pkg::*;
#(
    parameter int RST_CYCLES = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [REG_W-1:0] status,
    input logic [REG_W-1:0] sten,
    input logic [REG_W-1:0] sigen,
    input logic             irq,
    input logic [2:0]       rst_lines
);
    localparam int HC_W = $clog2(RST_CYCLES + 2);
    logic [HC_W-1:0] hi_cnt [3];

    // Count consecutive high cycles of each reset line, saturating
    always_ff @(posedge clk) begin
        for (int i = 0; i < 3; i++) begin
            if (!rst_n || !rst_lines[i])
                hi_cnt[i] <= '0;
            else if (hi_cnt[i] <= HC_W'(RST_CYCLES))
                hi_cnt[i] <= hi_cnt[i] + 1'b1;
        end
    end

    p_latch_needs_enable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & ~$past(status) & ~$past(sten)) == '0));

    p_irq_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(|(status & sigen))));

    p_reset_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_cnt[0] <= HC_W'(RST_CYCLES)) && (hi_cnt[1] <= HC_W'(RST_CYCLES))
        && (hi_cnt[2] <= HC_W'(RST_CYCLES)));

    p_enables_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_lines[0] |=> (sten == '0) && (sigen == '0) && (status == '0));

    p_unimpl_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((status | sten | sigen) & ~IMPL_MASK) == '0);
endmodule

bind sd_irq_status_unit sd_irq_checker #(.RST_CYCLES(RST_CYCLES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .status    (status_q),
    .sten      (sten_q),
    .sigen     (sigen_q),
    .irq       (irq_o),
    .rst_lines (rst_act)
);

// File: tb/tb_sd_irq_status_unit.sv
// Bench: directed tests, one task per scenario, each checking its own results.
module tb_sd_irq_status_unit;
    localparam int RSTC = 8;
    localparam logic [31:0] IMPL = 32'h107F_01FF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  sel = 2'd0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] evt = '0;
    logic        irq, cmd_err, err_any, r_all, r_cmd, r_dat;
    int          checks = 0;
    int          errors = 0;
    bit          done = 0;

    always #5 clk = ~clk;

    sd_irq_status_unit #(.RST_CYCLES(RSTC)) dut (
        .clk(clk), .rst_n(rst_n), .reg_sel_i(sel), .reg_we_i(we),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .evt_i(evt),
        .irq_o(irq), .cmd_err_o(cmd_err), .err_any_o(err_any),
        .rst_all_o(r_all), .rst_cmd_o(r_cmd), .rst_dat_o(r_dat)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    // One write, optionally with a simultaneous event pattern
    task automatic wr(input logic [1:0] s, input logic [31:0] d, input logic [31:0] e = '0);
        sel = s; we = 1'b1; wdata = d; evt = e;
        tick();
        we = 1'b0; wdata = '0; evt = '0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [31:0] d);
        sel = s; #1; d = rdata;
    endtask

    task automatic pulse(input logic [31:0] e);
        evt = e; tick(); evt = '0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int s = 0; s < 4; s++) begin
            rd(2'(s), v); chk("R10 reg", v, 32'h0);
        end
        chk("R10 outs", {26'd0, irq, cmd_err, err_any, r_all, r_cmd, r_dat}, 32'h0);
    endtask

    task automatic t_enable();
        logic [31:0] v;
        wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, v); chk("R9 sten", v, IMPL);
        wr(2'd2, 32'hFFFF_FFFF); rd(2'd2, v); chk("R9 sigen", v, IMPL);
        wr(2'd2, 32'h0);
        wr(2'd1, 32'h0000_0001);
        pulse(32'h0000_0003); rd(2'd0, v); chk("R1 gate", v, 32'h1);
        wr(2'd1, 32'hFFFF_FFFF);
        pulse(32'hEF80_FE00); rd(2'd0, v); chk("R9 unimpl", v, 32'h1);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        wr(2'd0, 32'h0); rd(2'd0, v); chk("R2 zero write", v, 32'h1);
        wr(2'd0, 32'h1); rd(2'd0, v); chk("R2 clear", v, 32'h0);
    endtask

    task automatic t_collision();
        logic [31:0] v;
        pulse(32'h2);
        wr(2'd0, 32'h2, 32'h2); rd(2'd0, v); chk("R3 event wins", v, 32'h2);
        wr(2'd0, 32'h2); rd(2'd0, v); chk("R3 later clear", v, 32'h0);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        pulse(32'h10); tick(); tick();
        chk("R4 masked irq", {31'd0, irq}, 32'h0);
        rd(2'd0, v); chk("R4 still latched", v, 32'h10);
        wr(2'd2, 32'h10);
        chk("R4 irq before latency", {31'd0, irq}, 32'h0);
        tick();
        chk("R4 irq after one cycle", {31'd0, irq}, 32'h1);
        wr(2'd0, 32'h10); tick();
        chk("R4 irq drops", {31'd0, irq}, 32'h0);
        wr(2'd2, 32'h0);
    endtask

    task automatic t_groups();
        pulse(32'h0004_0000);
        chk("R5 end-bit", {30'd0, cmd_err, err_any}, 32'h3);
        wr(2'd0, '1);
        pulse(32'h0001_0000);
        chk("R5 timeout not cmd group", {30'd0, cmd_err, err_any}, 32'h1);
        wr(2'd0, '1);
        pulse(32'h1000_0000);
        chk("R5 dma err", {30'd0, cmd_err, err_any}, 32'h1);
        wr(2'd0, '1);
        chk("R5 cleared", {30'd0, cmd_err, err_any}, 32'h0);
    endtask

    task automatic t_selfclear();
        logic [31:0] v;
        wr(2'd3, 32'h0200_0000);
        rd(2'd3, v); chk("R6 set", v, 32'h0200_0000);
        chk("R6 line", {29'd0, r_all, r_cmd, r_dat}, 32'h2);
        repeat (RSTC - 1) tick();
        rd(2'd3, v); chk("R6 last cycle", v, 32'h0200_0000);
        tick();
        rd(2'd3, v); chk("R6 cleared", v, 32'h0);
        chk("R6 line low", {29'd0, r_all, r_cmd, r_dat}, 32'h0);
    endtask

    task automatic t_path();
        logic [31:0] v;
        pulse(IMPL); rd(2'd0, v); chk("R8 all set", v, IMPL);
        wr(2'd3, 32'h0200_0000); repeat (RSTC) tick();
        rd(2'd0, v); chk("R8 cmd reset", v, 32'h1070_01FE);
        wr(2'd3, 32'h0400_0000); repeat (RSTC) tick();
        rd(2'd0, v); chk("R8 data reset", v, 32'h0000_01C0);
    endtask

    task automatic t_all();
        logic [31:0] v;
        wr(2'd2, 32'h1);
        wr(2'd3, 32'h0100_0000);
        chk("R7 line", {29'd0, r_all, r_cmd, r_dat}, 32'h4);
        repeat (RSTC) tick();
        rd(2'd0, v); chk("R7 status", v, 32'h0);
        rd(2'd1, v); chk("R7 sten", v, 32'h0);
        rd(2'd2, v); chk("R7 sigen", v, 32'h0);
        rd(2'd3, v); chk("R7 sysctl", v, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable();
        t_w1c();
        t_collision();
        t_irq();
        t_groups();
        t_selfclear();
        t_path();
        t_all();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule